// File: doc/BRIEF.md
# 64B/66B Transmit Framing Scheduler

This block turns a user transmit stream of 8-byte beats into a single lane of 64-bit coded blocks, one per user-clock cycle, each with a 2-bit sync header and a block-kind tag. Every accepted beat becomes one data block. Every frame is closed by a separator block, which sits alone in its cycle. A cycle with nothing to send carries an idle block.

Two timing duties are folded into the same scheduler. First, a fixed one-cycle stall recurs every `PAUSE_PERIOD` cycles. On that cycle the user sees `s_tready` low and no block leaves, which gives the downstream rate-matching stage room for the header overhead. Second, every `CC_PERIOD` cycles a burst of `CC_BURST` clock-compensation blocks falls due. The beat accepted in the cycle the burst falls due is completed first. The user is then held off until the whole burst has gone out.

Top module: `frame_tx_scheduler`

## Requirements
- R1: Data blocks carry sync header 2'b01 and kind 1. Control blocks carry sync header 2'b10 with a type byte in bits [7:0] and zeros elsewhere unless stated: idle is 8'h1E with kind 0, separator is 8'hB4 with kind 2, and clock compensation is 8'h55 with kind 3.
- R2: Cycle 0 is the cycle in which reset is released. In every cycle whose index modulo `PAUSE_PERIOD` (32) equals 31, `s_tready` is low.
- R3: `o_valid` is low exactly in the cycle that follows a pause cycle (index modulo 32 equal to 0, index > 0). In every other cycle `o_valid` is high.
- R4: A beat accepted in cycle c (`s_tvalid` and `s_tready` both high) appears in cycle c+1 as a data block. Beats come out in acceptance order. On a beat with `s_tlast`, bytes whose `s_tkeep` bit is 0 are zeroed. `s_tkeep` is contiguous from byte 0.
- R5: The next valid block after a frame's final data block is its separator. Bits [15:8] of the separator hold the number of set `s_tkeep` bits of the last beat when that beat is partial, and 0 when all 8 bits are set.
- R6: A separator goes out alone. `s_tready` is low in the cycle the separator is formed, so no data of the next frame shares that cycle.
- R7: In the cycle where the cycle index modulo `CC_PERIOD` equals `CC_PERIOD`-1, a burst of `CC_BURST` clock-compensation blocks falls due. All of them are emitted, `s_tready` is low in each cycle that forms one, and an uninterrupted burst spans at least three consecutive cycles.
- R8: A burst that would start on a pause cycle starts one cycle later. A pending separator goes out ahead of the burst. Pause cycles interrupt the burst without shortening it.
- R9: When no beat, separator, pause or burst is pending, the block emits an idle block.
- R10: While reset is high, `s_tready` is high and the output is a valid idle block. The first cycle after reset also shows an idle block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 64 | User beat, byte 0 in bits [7:0] |
| s_tkeep | input | 8 | Valid-byte mask, used on the last beat only |
| s_tvalid | input | 1 | User beat present |
| s_tlast | input | 1 | Final beat of the frame |
| s_tready | output | 1 | Beat accepted when high with `s_tvalid` |
| o_valid | output | 1 | A block is present this cycle |
| o_hdr | output | 2 | Sync header |
| o_kind | output | 2 | Block kind: 0 idle, 1 data, 2 separator, 3 clock compensation |
| o_data | output | 64 | Block payload |

## Verification
A drifting pause counter shows up within 32 cycles, as a missing `o_valid` gap or a `s_tready` that is high on a pause slot. A stuck separator flag shows up two cycles after a frame's last beat: the separator is missing, or it comes out late behind another block. A clock-compensation counter that is off by one moves the first burst away from its expected cycle, and a burst-length error changes the total number of compensation blocks counted by the end of the run. A lost or duplicated beat breaks the in-order comparison on the next data block.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int BLK_W     = 64;
  localparam int BLK_BYTES = BLK_W / 8;
  localparam int CNT_W     = 8;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_DATA = 2'd1,
    K_SEP  = 2'd2,
    K_CC   = 2'd3
  } blk_kind_e;

  localparam logic [1:0] SH_DATA = 2'b01;
  localparam logic [1:0] SH_CTRL = 2'b10;
  localparam logic [7:0] TY_IDLE = 8'h1E;
  localparam logic [7:0] TY_SEP  = 8'hB4;
  localparam logic [7:0] TY_CC   = 8'h55;

  // Byte count of a partial closing beat; a full beat reports zero.
  function automatic logic [CNT_W-1:0] tail_bytes(input logic [BLK_BYTES-1:0] keep);
    logic [CNT_W-1:0] n;
    n = '0;
    if (!(&keep)) begin
      for (int i = 0; i < BLK_BYTES; i++) n = n + CNT_W'(keep[i]);
    end
    return n;
  endfunction
endpackage

// File: rtl/fts_pause_timer.sv
module fts_pause_timer #(
  parameter int PERIOD = 32
) (
  input  logic clk,
  input  logic rst,
  output logic pause_now
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign pause_now = (cnt == LAST);
endmodule

// File: rtl/fts_cc_scheduler.sv
module fts_cc_scheduler #(
  parameter int PERIOD = 4992,
  parameter int BURST  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic busy,
  output logic emit
);
  localparam int CW = $clog2(PERIOD);
  localparam int LW = $clog2(BURST + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] tick;
  logic [LW-1:0] left;
  logic          due;

  assign due  = (tick == LAST);
  assign busy = (left != '0);
  assign emit = busy && !hold;

  always_ff @(posedge clk) begin
    if (rst)      tick <= '0;
    else if (due) tick <= '0;
    else          tick <= tick + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       left <= '0;
    else if (due)  left <= LW'(BURST);
    else if (emit) left <= left - 1'b1;
  end
endmodule

// File: rtl/fts_block_former.sv
module fts_block_former
  import fts_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 nxt_vld,
  input  blk_kind_e            nxt_kind,
  input  logic [BLK_W-1:0]     beat,
  input  logic [BLK_BYTES-1:0] keep,
  input  logic                 beat_last,
  input  logic [CNT_W-1:0]     sep_cnt,
  output logic                 o_valid,
  output logic [1:0]           o_hdr,
  output blk_kind_e            o_kind,
  output logic [BLK_W-1:0]     o_data
);
  localparam int PAD_W = BLK_W - 8;
  localparam int SEP_PAD_W = BLK_W - CNT_W - 8;

  logic [BLK_W-1:0] masked;
  logic [BLK_W-1:0] word;
  logic [1:0]       hdr;

  generate
    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_mask
      assign masked[8*b +: 8] = (!beat_last || keep[b]) ? beat[8*b +: 8] : 8'h00;
    end
  endgenerate

  always_comb begin
    hdr  = SH_CTRL;
    word = {{PAD_W{1'b0}}, TY_IDLE};
    unique case (nxt_kind)
      K_DATA: begin
        hdr  = SH_DATA;
        word = masked;
      end
      K_SEP:  word = {{SEP_PAD_W{1'b0}}, sep_cnt, TY_SEP};
      K_CC:   word = {{PAD_W{1'b0}}, TY_CC};
      default: word = {{PAD_W{1'b0}}, TY_IDLE};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b1;
      o_hdr   <= SH_CTRL;
      o_kind  <= K_IDLE;
      o_data  <= {{PAD_W{1'b0}}, TY_IDLE};
    end else begin
      o_valid <= nxt_vld;
      o_hdr   <= hdr;
      o_kind  <= nxt_kind;
      o_data  <= word;
    end
  end
endmodule

// File: rtl/frame_tx_scheduler.sv
module frame_tx_scheduler
  import fts_pkg::*;
#(
  parameter int PAUSE_PERIOD = 32,
  parameter int CC_PERIOD    = 4992,
  parameter int CC_BURST     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BLK_W-1:0]     s_tdata,
  input  logic [BLK_BYTES-1:0] s_tkeep,
  input  logic                 s_tvalid,
  input  logic                 s_tlast,
  output logic                 s_tready,
  output logic                 o_valid,
  output logic [1:0]           o_hdr,
  output logic [1:0]           o_kind,
  output logic [BLK_W-1:0]     o_data
);
  logic             pause_now;
  logic             cc_busy;
  logic             cc_emit;
  logic             sep_pend;
  logic [CNT_W-1:0] sep_cnt;
  logic             fire;
  logic             nxt_vld;
  blk_kind_e        nxt_kind;
  blk_kind_e        kind_q;

  fts_pause_timer #(.PERIOD(PAUSE_PERIOD)) u_pause (
    .clk       (clk),
    .rst       (rst),
    .pause_now (pause_now)
  );

  fts_cc_scheduler #(.PERIOD(CC_PERIOD), .BURST(CC_BURST)) u_cc (
    .clk  (clk),
    .rst  (rst),
    .hold (pause_now || sep_pend),
    .busy (cc_busy),
    .emit (cc_emit)
  );

  assign s_tready = !pause_now && !sep_pend && !cc_busy;
  assign fire     = s_tvalid && s_tready;

  // Frame close: the separator goes out on the next non-pause cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      sep_pend <= 1'b0;
      sep_cnt  <= '0;
    end else if (fire && s_tlast) begin
      sep_pend <= 1'b1;
      sep_cnt  <= tail_bytes(s_tkeep);
    end else if (sep_pend && !pause_now) begin
      sep_pend <= 1'b0;
    end
  end

  // Slot priority: pause, separator, compensation, user beat, idle.
  always_comb begin
    nxt_vld  = 1'b1;
    nxt_kind = K_IDLE;
    if (pause_now)     nxt_vld  = 1'b0;
    else if (sep_pend) nxt_kind = K_SEP;
    else if (cc_emit)  nxt_kind = K_CC;
    else if (fire)     nxt_kind = K_DATA;
  end

  fts_block_former u_form (
    .clk       (clk),
    .rst       (rst),
    .nxt_vld   (nxt_vld),
    .nxt_kind  (nxt_kind),
    .beat      (s_tdata),
    .keep      (s_tkeep),
    .beat_last (s_tlast),
    .sep_cnt   (sep_cnt),
    .o_valid   (o_valid),
    .o_hdr     (o_hdr),
    .o_kind    (kind_q),
    .o_data    (o_data)
  );

  assign o_kind = kind_q;
endmodule

// File: rtl/fts_chk.sv
module fts_chk
  import fts_pkg::*;
#(
  parameter int PAUSE_PERIOD = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       s_tvalid,
  input logic       s_tlast,
  input logic       s_tready,
  input logic       o_valid,
  input logic [1:0] o_hdr,
  input logic [1:0] o_kind
);
  localparam int PW = (PAUSE_PERIOD > 1) ? $clog2(PAUSE_PERIOD) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PAUSE_PERIOD - 1);

  logic [PW-1:0] slot;
  always_ff @(posedge clk) begin
    if (rst)               slot <= '0;
    else if (slot == PLAST) slot <= '0;
    else                   slot <= slot + 1'b1;
  end

  a_r1_header: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_hdr == ((o_kind == K_DATA) ? SH_DATA : SH_CTRL)));

  a_r2_pause_slot: assert property (@(posedge clk) disable iff (rst)
    (slot == PLAST) |-> !s_tready);

  a_r3_gap_follows_stall: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> $past(!s_tready));

  a_r4_beat_out: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && s_tready) |=> (o_valid && o_kind == K_DATA));

  a_r5_close_follows: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && s_tready && s_tlast) |-> ##2 (!o_valid || o_kind == K_SEP));

  a_r6_sep_alone: assert property (@(posedge clk) disable iff (rst)
    (o_valid && o_kind == K_SEP) |-> $past(!s_tready));

  a_r7_cc_stall: assert property (@(posedge clk) disable iff (rst)
    (o_valid && o_kind == K_CC) |-> $past(!s_tready));
endmodule

bind frame_tx_scheduler fts_chk #(.PAUSE_PERIOD(PAUSE_PERIOD)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .s_tvalid (s_tvalid),
  .s_tlast  (s_tlast),
  .s_tready (s_tready),
  .o_valid  (o_valid),
  .o_hdr    (o_hdr),
  .o_kind   (o_kind)
);

// File: tb/tb_frame_tx_scheduler.sv
module tb_frame_tx_scheduler;
  localparam int CCP = 95;
  localparam int CCB = 8;
  localparam int NF  = 8;
  // {beats, keep of last beat, idle gap after frame}
  localparam logic [23:0] FRAMES [NF] = '{
    {8'd4,  8'hFF, 8'd2}, {8'd3, 8'h0F, 8'd0}, {8'd1, 8'h01, 8'd1},
    {8'd32, 8'hFF, 8'd3}, {8'd2, 8'h7F, 8'd0}, {8'd5, 8'h03, 8'd4},
    {8'd1,  8'hFF, 8'd0}, {8'd6, 8'h3F, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] s_tdata = '0;
  logic [7:0]  s_tkeep = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic        s_tready;
  logic        o_valid;
  logic [1:0]  o_hdr;
  logic [1:0]  o_kind;
  logic [63:0] o_data;

  int checks = 0, fails = 0, cyc = 0;
  int cc_total = 0, first_cc = 0, last_cc = -10, run = 0, max_run = 0;
  bit prev_ready = 1'b1, sep_exp = 1'b0;
  logic [7:0] sep_cnt_exp = '0;
  logic [63:0] q_data[$];
  bit          q_last[$];
  logic [7:0]  q_cnt[$];

  always #4 clk = ~clk;

  frame_tx_scheduler #(.CC_PERIOD(CCP), .CC_BURST(CCB)) dut (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
    .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .o_valid(o_valid), .o_hdr(o_hdr), .o_kind(o_kind), .o_data(o_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (!rst) begin
      logic [63:0] ed;
      bit          el;
      logic [7:0]  ec;
      cyc++;
      if (cyc == 1) chk(o_valid && o_kind == 2'd0, "R10 first cycle idle", {62'd0, o_kind}, 64'd0);
      if (cyc % 32 == 31) chk(!s_tready, "R2 pause stall", {63'd0, s_tready}, 64'd0);
      chk(o_valid == (cyc % 32 != 0), "R3 valid gap", {63'd0, o_valid}, {63'd0, (cyc % 32 != 0)});
      if (cyc < 97 && o_valid) chk(o_kind == 2'd0, "R9 idle before traffic", {62'd0, o_kind}, 64'd0);
      if (o_valid) begin
        case (o_kind)
          2'd1: begin
            chk(o_hdr == 2'b01, "R1 data header", {62'd0, o_hdr}, 64'd1);
            chk(!sep_exp, "R5 separator missing", 64'd1, 64'd2);
            if (q_data.size() == 0) chk(1'b0, "R4 unexpected data block", o_data, 64'd0);
            else begin
              ed = q_data.pop_front(); el = q_last.pop_front(); ec = q_cnt.pop_front();
              chk(o_data == ed, "R4 data payload", o_data, ed);
              if (el) begin sep_exp = 1'b1; sep_cnt_exp = ec; end
            end
          end
          2'd2: begin
            chk(sep_exp, "R5 separator without frame end", 64'd2, 64'd1);
            chk(o_hdr == 2'b10 && o_data == {48'd0, sep_cnt_exp, 8'hB4}, "R5 separator word",
                o_data, {48'd0, sep_cnt_exp, 8'hB4});
            chk(!prev_ready, "R6 separator alone", {63'd0, prev_ready}, 64'd0);
            sep_exp = 1'b0;
          end
          2'd3: begin
            chk(o_hdr == 2'b10 && o_data == 64'h55, "R1 cc word", o_data, 64'h55);
            chk(!prev_ready, "R7 cc stalls user", {63'd0, prev_ready}, 64'd0);
            cc_total++;
            if (first_cc == 0) first_cc = cyc;
            run = (last_cc == cyc - 1) ? run + 1 : 1;
            if (run > max_run) max_run = run;
            last_cc = cyc;
          end
          default: begin
            chk(o_hdr == 2'b10 && o_data == 64'h1E, "R1 idle word", o_data, 64'h1E);
            chk(q_data.size() == 0 && !sep_exp, "R9 idle only when nothing pending",
                64'(q_data.size()), 64'd0);
          end
        endcase
      end
      prev_ready = s_tready;
    end
  end

  task automatic send_frame(input int fid, input int nb, input logic [7:0] lk);
    for (int b = 0; b < nb; b++) begin
      logic [63:0] d, m;
      bit last;
      last = (b == nb - 1);
      d = {16'(fid), 16'(b), 32'hC0DE_5A00 ^ 32'(b * 7 + fid)};
      s_tdata = d; s_tvalid = 1'b1; s_tlast = last; s_tkeep = last ? lk : 8'hFF;
      while (!s_tready) tick();
      m = d;
      if (last) for (int i = 0; i < 8; i++) if (!lk[i]) m[8*i +: 8] = 8'h00;
      q_data.push_back(m);
      q_last.push_back(last);
      q_cnt.push_back((last && lk != 8'hFF) ? 8'($countones(lk)) : 8'd0);
      tick();
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(s_tready, "R10 ready in reset", {63'd0, s_tready}, 64'd1);
    chk(o_valid && o_kind == 2'd0, "R10 idle in reset", {62'd0, o_kind}, 64'd0);
    chk(o_hdr == 2'b10 && o_data == 64'h1E, "R10 idle word in reset", o_data, 64'h1E);
    #1 rst = 1'b0;
    while (cyc < 110) tick();
    for (int p = 0; p < 9; p++) begin
      for (int f = 0; f < NF; f++) begin
        send_frame(p * NF + f, int'(FRAMES[f][23:16]), FRAMES[f][15:8]);
        for (int g = 0; g < int'(FRAMES[f][7:0]); g++) tick();
      end
    end
    while (cyc % CCP != 60) tick();
    chk(first_cc == 97, "R8 first burst deferred past pause", 64'(first_cc), 64'd97);
    chk(cc_total == CCB * ((cyc + 1) / CCP), "R7 cc block count",
        64'(cc_total), 64'(CCB * ((cyc + 1) / CCP)));
    chk(max_run >= 3, "R7 burst length", 64'(max_run), 64'd3);
    chk(q_data.size() == 0 && !sep_exp, "R4 all beats delivered", 64'(q_data.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule